// File: doc/BRIEF.md
# Command Issue, Completion Status and Interrupt Unit

This block sits between a register interface and a card port. Software loads a 32-bit argument and then writes a 16-bit command word. If the controller is enabled, the block splits that word into its fields, clears the response store and sends a request to the card for one cycle. When the card answers with a valid strobe, a byte count and up to sixteen bytes, the block judges the answer against the requested response type. It then fills eight 16-bit response registers and records the outcome in a 16-bit status register.

Status bits are write-one-to-clear. A 15-bit enable mask selects which of them raise the interrupt line. A rising edge on the card-detect input sets its own status bit. Writing the control register with its enable bit low returns every register to its reset value.

Top module: `cmd_status_unit`

## Requirements
- R1: A command write (address 0) while the enable bit (control register, address 3, bit 0) is clear starts nothing and leaves the command readback unchanged.
- R2: A command word with bit 7 set and bits 5:0 equal to zero starts no card request. Status bit 0 is set after the next clock.
- R3: The response type is in command bits 10:8. Code 1 is R1, and code 1 with busy bit 11 set is R1b, treated the same. Code 2 is R2, code 3 is R3 and code 6 is R6. Every other code means no response. R1, R3 and R6 need at least 4 bytes and R2 needs 16. A shorter answer sets status bit 7 and not bit 0, and the response registers stay zero.
- R4: Response register 7-i (read at address 8+(7-i)) holds byte 2i in bits 15:8 and byte 2i+1 in bits 7:0. Bytes are taken from `card_rsp_data`, where byte k occupies bits 8k+7:8k. An accepted command write clears all eight registers.
- R5: For R3, the returned word is byte0..byte3 with byte0 most significant. If bit 31 of that word is set, status is ANDed with 0xE000. Otherwise status bit 12 is set.
- R6: For R1, status bit 14 is set when the word ANDed with 0xFDF90000 is nonzero. For R6, it is set when the low 16 bits ANDed with 0xE008 are nonzero.
- R7: A successful command with index 12 sets status bits 0 and 2. Any other successful command sets bit 0 only.
- R8: Writing the status register (address 4) clears exactly the bits written as 1. Bits set by an event in the same cycle win.
- R9: The interrupt enable register (address 5) keeps only bits 14:0. `irq` is high exactly when status AND enable is nonzero.
- R10: A low-to-high transition of `card_detect` sets status bit 1.
- R11: After reset, and after a control write with bit 0 clear, the command, argument (addresses 1 and 2), control, status, enable and response registers read zero, and any pending command is dropped.
- R12: An accepted command raises `card_start` for exactly one cycle, with `card_cmd` and `card_arg` valid. Command writes made before the answer has been processed are ignored. Status and response registers change one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| card_detect | input | 1 | Card-detect level |
| card_start | output | 1 | One-cycle card request |
| card_cmd | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_rsp_valid | input | 1 | Card answer strobe |
| card_rsp_len | input | 5 | Number of answer bytes, 0 to 16 |
| card_rsp_data | input | 128 | Answer bytes, byte k at bits 8k+7:8k |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the card raises its strobe only while a request is outstanding, and never more than once per request. They also assume that the reported length never exceeds sixteen. The bench therefore drives each answer once, a cycle or more after the request pulse, with lengths from 0 to 16. The timing assertions also assume that register writes and card-detect edges are driven between clock edges. The bench drives them one time unit after the falling edge.

// File: rtl/cmd_status_unit.sv
module cmd_status_unit #(
  parameter logic [5:0]  CMD_STOP    = 6'd12,
  parameter logic [31:0] ERR_MASK_R1 = 32'hFDF9_0000,
  parameter logic [15:0] ERR_MASK_R6 = 16'hE008,
  parameter logic [15:0] R3_KEEP     = 16'hE000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [3:0]   reg_addr,
  input  logic [15:0]  reg_wdata,
  output logic [15:0]  reg_rdata,
  input  logic         card_detect,
  output logic         card_start,
  output logic [5:0]   card_cmd,
  output logic [31:0]  card_arg,
  input  logic         card_rsp_valid,
  input  logic [4:0]   card_rsp_len,
  input  logic [127:0] card_rsp_data,
  output logic         irq
);
  localparam logic [3:0] A_CMD  = 4'd0;
  localparam logic [3:0] A_ARGL = 4'd1;
  localparam logic [3:0] A_ARGH = 4'd2;
  localparam logic [3:0] A_CTRL = 4'd3;
  localparam logic [3:0] A_STAT = 4'd4;
  localparam logic [3:0] A_IEN  = 4'd5;

  logic [15:0]       last_cmd, stat, ien, s_nx;
  logic [31:0]       arg;
  logic              en, waiting, pend, cd_q;
  logic [7:0][15:0]  rsp;
  logic [4:0]        cap_len;
  logic [127:0]      cap_data;

  wire wr_cmd     = reg_wr && (reg_addr == A_CMD);
  wire init0      = reg_wdata[7] && (reg_wdata[5:0] == 6'd0);
  wire cmd_ok     = wr_cmd && en && !waiting && !pend;
  wire disable_wr = reg_wr && (reg_addr == A_CTRL) && !reg_wdata[0];

  wire [2:0] rtype = last_cmd[10:8];
  wire t_r1 = (rtype == 3'd1);
  wire t_r2 = (rtype == 3'd2);
  wire t_r3 = (rtype == 3'd3);
  wire t_r6 = (rtype == 3'd6);
  wire short_rsp = ((t_r1 || t_r3 || t_r6) && (cap_len < 5'd4)) ||
                   (t_r2 && (cap_len < 5'd16));
  wire has_rsp = (t_r1 || t_r2 || t_r3 || t_r6) && !short_rsp;
  wire [31:0] word = {cap_data[7:0], cap_data[15:8], cap_data[23:16], cap_data[31:24]};
  wire err = !short_rsp && ((t_r1 && |(word & ERR_MASK_R1)) ||
                            (t_r6 && |(word[15:0] & ERR_MASK_R6)));

  assign card_cmd = last_cmd[5:0];
  assign card_arg = arg;
  assign irq      = |(stat & ien);

  always_comb begin
    s_nx = stat;
    if (reg_wr && (reg_addr == A_STAT)) s_nx = s_nx & ~reg_wdata;
    if (pend) begin
      if (short_rsp) s_nx[7] = 1'b1;
      else begin
        if (t_r3) begin
          if (word[31]) s_nx = s_nx & R3_KEEP;
          else s_nx[12] = 1'b1;
        end
        if (err) s_nx[14] = 1'b1;
        s_nx[0] = 1'b1;
        if (last_cmd[5:0] == CMD_STOP) s_nx[2] = 1'b1;
      end
    end
    if (cmd_ok && init0) s_nx[0] = 1'b1;
    if (card_detect && !cd_q) s_nx[1] = 1'b1;
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = last_cmd;
      A_ARGL:  reg_rdata = arg[15:0];
      A_ARGH:  reg_rdata = arg[31:16];
      A_CTRL:  reg_rdata = {15'd0, en};
      A_STAT:  reg_rdata = stat;
      A_IEN:   reg_rdata = ien;
      default: reg_rdata = reg_addr[3] ? rsp[reg_addr[2:0]] : 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd   <= '0;
      arg        <= '0;
      en         <= 1'b0;
      stat       <= '0;
      ien        <= '0;
      waiting    <= 1'b0;
      pend       <= 1'b0;
      cd_q       <= 1'b0;
      card_start <= 1'b0;
      rsp        <= '0;
      cap_len    <= '0;
      cap_data   <= '0;
    end else begin
      cd_q       <= card_detect;
      card_start <= cmd_ok && !init0;
      if (disable_wr) begin
        last_cmd <= '0;
        arg      <= '0;
        en       <= 1'b0;
        stat     <= '0;
        ien      <= '0;
        waiting  <= 1'b0;
        pend     <= 1'b0;
        rsp      <= '0;
      end else begin
        stat <= s_nx;
        if (reg_wr) begin
          case (reg_addr)
            A_CMD: if (cmd_ok) begin
              last_cmd <= reg_wdata;
              rsp      <= '0;
              waiting  <= !init0;
            end
            A_ARGL: arg[15:0]  <= reg_wdata;
            A_ARGH: arg[31:16] <= reg_wdata;
            A_CTRL: en  <= 1'b1;
            A_IEN:  ien <= {1'b0, reg_wdata[14:0]};
            default: ;
          endcase
        end
        pend <= waiting && card_rsp_valid;
        if (waiting && card_rsp_valid) begin
          waiting  <= 1'b0;
          cap_len  <= card_rsp_len;
          cap_data <= card_rsp_data;
        end
        if (pend && has_rsp) begin
          for (int i = 0; i < 8; i++)
            rsp[7-i] <= {cap_data[16*i +: 8], cap_data[16*i+8 +: 8]};
        end
      end
    end
  end
endmodule

module cmd_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic        wd0,
  input logic        wd_init,
  input logic [5:0]  wd_idx,
  input logic        card_detect,
  input logic        card_start,
  input logic        irq,
  input logic [15:0] stat,
  input logic        en
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    card_start |=> !card_start); // R12
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && !en) |=> !card_start); // R1
  AST_INIT0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && wd_init && wd_idx == 6'd0) |=> !card_start); // R2
  AST_DONE_XOR_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(stat[0]) && $rose(stat[7]))); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd3 && !wd0) |=> (stat == 16'd0 && !irq)); // R11
  AST_CDET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_detect) && !(reg_wr && reg_addr == 4'd3 && !wd0)) |=> stat[1]); // R10
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != 16'd0)); // R9
endmodule

bind cmd_status_unit cmd_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd0(reg_wdata[0]), .wd_init(reg_wdata[7]), .wd_idx(reg_wdata[5:0]),
  .card_detect(card_detect), .card_start(card_start), .irq(irq),
  .stat(stat), .en(en)
);

// File: tb/sim_cmd_status_unit.sv
module sim_cmd_status_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic card_detect = 1'b0;
  logic card_start;
  logic [5:0] card_cmd;
  logic [31:0] card_arg;
  logic card_rsp_valid = 1'b0;
  logic [4:0] card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic irq;

  int checks = 0, errors = 0, cyc = 0;

  cmd_status_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [15:0] m_last, m_stat, m_ien, m_argl, m_argh;
  logic [15:0] m_rsp [8];
  bit m_en, m_wait, m_pend, m_cd, m_start;
  int m_len;
  logic [7:0] m_data [16];

  task automatic model_clear();
    m_last = 0; m_stat = 0; m_ien = 0; m_argl = 0; m_argh = 0;
    m_en = 0; m_wait = 0; m_pend = 0; m_start = 0;
    for (int i = 0; i < 8; i++) m_rsp[i] = 0;
  endtask

  task automatic model_step();
    logic [15:0] s;
    logic [31:0] w;
    int t, need;
    bit ok, i0;
    s  = m_stat;
    t  = int'(m_last[10:8]);
    ok = reg_wr && reg_addr == 0 && m_en && !m_wait && !m_pend;
    i0 = reg_wdata[7] && reg_wdata[5:0] == 0;
    if (reg_wr && reg_addr == 3 && !reg_wdata[0]) begin
      model_clear();
      m_cd = card_detect;
      return;
    end
    if (reg_wr && reg_addr == 4) s = s & ~reg_wdata;
    if (m_pend) begin
      need = (t == 2) ? 16 : (t == 1 || t == 3 || t == 6) ? 4 : 0;
      w = {m_data[0], m_data[1], m_data[2], m_data[3]};
      if (m_len < need) s[7] = 1;
      else begin
        if (t == 3) begin
          if (w[31]) s = s & 16'hE000; else s[12] = 1;
        end
        if (t == 1 && (w & 32'hFDF90000) != 0) s[14] = 1;
        if (t == 6 && (w[15:0] & 16'hE008) != 0) s[14] = 1;
        s[0] = 1;
        if (m_last[5:0] == 12) s[2] = 1;
        if (need > 0)
          for (int i = 0; i < 8; i++) m_rsp[7-i] = {m_data[2*i], m_data[2*i+1]};
      end
    end
    if (ok && i0) s[0] = 1;
    if (card_detect && !m_cd) s[1] = 1;
    m_cd = card_detect;
    m_pend = m_wait && card_rsp_valid;
    if (m_pend) begin
      m_wait = 0;
      m_len = int'(card_rsp_len);
      for (int k = 0; k < 16; k++) m_data[k] = card_rsp_data[8*k +: 8];
    end
    m_start = ok && !i0;
    if (reg_wr) begin
      case (reg_addr)
        0: if (ok) begin
          m_last = reg_wdata;
          for (int i = 0; i < 8; i++) m_rsp[i] = 0;
          m_wait = !i0;
        end
        1: m_argl = reg_wdata;
        2: m_argh = reg_wdata;
        3: m_en = 1;
        5: m_ien = reg_wdata & 16'h7FFF;
        default: ;
      endcase
    end
    m_stat = s;
  endtask

  function automatic logic [15:0] model_read(logic [3:0] a);
    case (a)
      0: return m_last;
      1: return m_argl;
      2: return m_argh;
      3: return {15'd0, m_en};
      4: return m_stat;
      5: return m_ien;
      default: return a[3] ? m_rsp[a[2:0]] : 16'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin model_clear(); m_cd = 0; end
    else model_step();
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check("R9 irq vs model", {31'd0, irq}, {31'd0, (m_stat & m_ien) != 0});
      check("R12 card_start vs model", {31'd0, card_start}, {31'd0, m_start});
      check(reg_addr == 4 ? "R8 status readback vs model" :
            reg_addr[3] ? "R4 response readback vs model" : "R1 readback vs model",
            {16'd0, reg_rdata}, {16'd0, model_read(reg_addr)});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk); #1;
    reg_addr = a; #1;
    check(tag, {16'd0, reg_rdata}, {16'd0, exp});
  endtask

  function automatic logic [127:0] mk(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = 8'h10 + 8'(k);
    r[31:0] = {b3, b2, b1, b0};
    return r;
  endfunction

  task automatic respond(int len, logic [127:0] data);
    @(negedge clk); #1;
    card_rsp_valid = 1; card_rsp_len = 5'(len); card_rsp_data = data;
    @(negedge clk); #1;
    card_rsp_valid = 0;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(4, 16'h0000, "R11 status after reset");
    rd(0, 16'h0000, "R11 command after reset");
    check("R11 irq after reset", {31'd0, irq}, 32'd0);

    // R1: disabled
    wr(0, 16'h0111);
    check("R1 no start while disabled", {31'd0, card_start}, 32'd0);
    rd(0, 16'h0000, "R1 command not taken");

    wr(3, 16'h0001);
    wr(5, 16'hFFFF);
    rd(5, 16'h7FFF, "R9 enable keeps 14:0");

    // R2: init with index 0
    wr(0, 16'h0080);
    check("R2 no start on init0", {31'd0, card_start}, 32'd0);
    rd(4, 16'h0001, "R2 end of command");
    check("R9 irq raised", {31'd0, irq}, 32'd1);
    wr(4, 16'h0001);
    rd(4, 16'h0000, "R8 write one clears");
    check("R9 irq dropped", {31'd0, irq}, 32'd0);

    // R1 good response
    wr(1, 16'h1234); wr(2, 16'hABCD);
    wr(0, 16'h0111);
    check("R12 start pulse", {31'd0, card_start}, 32'd1);
    check("R12 card_cmd", {26'd0, card_cmd}, 32'd17);
    check("R12 card_arg", card_arg, 32'hABCD1234);
    wr(0, 16'h0105);
    rd(0, 16'h0111, "R12 write while pending ignored");
    respond(6, mk(8'h00, 8'h00, 8'h09, 8'h00));
    rd(4, 16'h0001, "R7 plain completion");
    rd(15, 16'h0000, "R4 rsp7 bytes 0,1");
    rd(14, 16'h0900, "R4 rsp6 bytes 2,3");
    rd(13, 16'h1415, "R4 rsp5 bytes 4,5");
    rd(8,  16'h1E1F, "R4 rsp0 bytes 14,15");
    wr(4, 16'hFFFF);

    // R1b with error
    wr(0, 16'h0911);
    rd(14, 16'h0000, "R4 cleared on new command");
    respond(4, mk(8'h80, 8'h00, 8'h00, 8'h00));
    rd(4, 16'h4001, "R6 R1b error flag");
    wr(4, 16'hFFFF);

    // R2 short: timeout
    wr(0, 16'h0202);
    respond(8, mk(8'h01, 8'h02, 8'h03, 8'h04));
    rd(4, 16'h0080, "R3 short R2 timeout");
    rd(15, 16'h0000, "R3 no response stored on timeout");
    wr(4, 16'hFFFF);

    // no response type
    wr(0, 16'h0005);
    respond(0, mk(8'hFF, 8'hFF, 8'hFF, 8'hFF));
    rd(4, 16'h0001, "R3 no-response type completes");
    rd(15, 16'h0000, "R3 no-response leaves registers zero");
    wr(4, 16'hFFFF);

    // R10 card detect, then R3 ready masks it
    @(negedge clk); #1; card_detect = 1;
    @(negedge clk); @(negedge clk);
    rd(4, 16'h0002, "R10 card detect edge");
    wr(0, 16'h0301);
    respond(4, mk(8'h80, 8'hFF, 8'h80, 8'h00));
    rd(4, 16'h0001, "R5 ready masks status");
    wr(0, 16'h0301);
    respond(4, mk(8'h00, 8'hFF, 8'h80, 8'h00));
    rd(4, 16'h1001, "R5 busy flag");
    wr(4, 16'h1000);
    rd(4, 16'h0001, "R8 partial clear");
    wr(4, 16'hFFFF);

    // R6
    wr(0, 16'h0603);
    respond(4, mk(8'h12, 8'h34, 8'h20, 8'h00));
    rd(4, 16'h4001, "R6 R6 error bits");
    wr(4, 16'hFFFF);
    wr(0, 16'h0603);
    respond(4, mk(8'h12, 8'h34, 8'h05, 8'h00));
    rd(4, 16'h0001, "R6 R6 clean");
    wr(4, 16'hFFFF);

    // R7 stop
    wr(0, 16'h010C);
    respond(4, mk(8'h00, 8'h00, 8'h00, 8'h00));
    rd(4, 16'h0005, "R7 stop sets bits 0 and 2");

    // R9 masking
    wr(5, 16'h0002);
    check("R9 masked status gives no irq", {31'd0, irq}, 32'd0);
    wr(5, 16'h0004);
    check("R9 enabled bit gives irq", {31'd0, irq}, 32'd1);

    // R11 disable
    wr(3, 16'h0000);
    rd(4, 16'h0000, "R11 status cleared");
    rd(5, 16'h0000, "R11 enable cleared");
    rd(0, 16'h0000, "R11 command cleared");
    rd(1, 16'h0000, "R11 argument cleared");
    check("R11 irq low", {31'd0, irq}, 32'd0);
    wr(0, 16'h0111);
    check("R1 ignored after disable", {31'd0, card_start}, 32'd0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule